// File: doc/BRIEF.md
# Pin Interrupt Detector and Target Router

This block turns a set of already-synchronized pin levels into interrupt requests. For each pin, a 9-bit configuration word picks a trigger kind, a polarity, a processor target and two extra options. When a pin's trigger condition is met, a sticky per-pin status flag is recorded. Software can read each flag, and it can force a flag to 0 or 1 through a per-pin write strobe.

Six summary interrupt lines each collect the pins routed to them. A summary line is high while any pin that is enabled, has its flag set and names that line as its target. A pin can also drive its own direct interrupt line with its qualified trigger event. That line is registered and stays high for one cycle per event. A raw-record option lets a pin keep recording status while its summary contribution is switched off. When this option is off, a disabled pin records nothing, which saves power.

Pin synchronization and the register bus sit outside the block. The configuration words come in as a flat vector, one word per pin.

Top module: `gpio_irq_router`

## Requirements
- R1: While reset is asserted, every status flag, every summary line and every direct line is 0. On the first clock after reset is released, no edge is detected, even if a pin is already high.
- R2: A pin's configuration word uses these bits: bit 0 enable, bit 1 polarity, bits 3:2 trigger kind, bit 4 raw-record, bits 7:5 target, bit 8 direct-line enable. Word i occupies bits [9*i+8 : 9*i] of the flat vector.
- R3: Trigger kind 00 is level mode. The event is true in every cycle in which the pin equals the polarity bit (1 means active high, 0 means active low). The flag therefore sets again on the clock after a software clear if the pin is still at its active level.
- R4: Trigger kind 01 detects a rising edge. The event is true when the pin is 1 and was 0 on the previous clock. A pin that simply stays high does not set the flag again. The polarity bit is ignored in every edge mode.
- R5: Trigger kind 10 detects a falling edge. The event is true when the pin is 0 and was 1 on the previous clock.
- R6: Trigger kind 11 detects both edges. Any change of the pin level between two clocks is an event.
- R7: A software write with value 0 clears the flag and a write with value 1 sets it. A write takes priority over a trigger event in the same cycle. The flag is readable on the status output one clock after the write.
- R8: An event sets the flag only if the enable bit or the raw-record bit is 1. With both bits at 0, events leave the flag unchanged.
- R9: Summary line t (t = 0..5) is the OR, over all pins, of enable AND flag AND (target == t). It follows the flags with no extra delay. Target codes 6 and 7 route the pin to no line.
- R10: When the direct-line enable is 1, a pin's direct line is high for the clock after each event. This does not depend on the enable bit. When the direct-line enable is 0, the direct line stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NUM_PINS | Synchronized pin levels |
| cfg_flat | input | 9*NUM_PINS | Per-pin configuration words, pin 0 in the low bits |
| sw_wr_en | input | NUM_PINS | Per-pin status write strobe |
| sw_wr_val | input | NUM_PINS | Value to write into the status flag |
| status_q | output | NUM_PINS | Sticky status flags |
| summary_irq | output | 6 | Summary interrupt per processor target |
| direct_irq | output | NUM_PINS | Registered per-pin direct interrupt |

## Verification
Each trigger kind is driven with the same pin waveform: low, rise, held high, fall and held low. Running that waveform through level, rising, falling and both-edge modes separates them, because each mode sets the flag on a different subset of those cycles. Level mode is also tried with both polarities.

Clears issued while the pin stays active separate level mode, where the flag re-sets, from the edge modes, where it does not. Sweeping the target code through all eight values while two pins share a target tests the routing decode and the OR merge. Toggling the enable bit against the raw-record bit tests the recording gate apart from the summary gate.

// File: rtl/gir_pkg.sv
package gir_pkg;
  localparam int CFG_W   = 9;
  localparam int TGT_W   = 3;
  localparam int NUM_TGT = 6;

  typedef enum logic [1:0] {
    DET_LEVEL = 2'b00,
    DET_RISE  = 2'b01,
    DET_FALL  = 2'b10,
    DET_BOTH  = 2'b11
  } det_e;

  typedef struct packed {
    logic             dc_en;
    logic [TGT_W-1:0] tgt;
    logic             raw_en;
    det_e             det;
    logic             pol;
    logic             en;
  } pin_cfg_t;
endpackage

// File: rtl/gir_detect.sv
module gir_detect
  import gir_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  det_e det_i,
  input  logic pol_i,
  output logic event_o
);
  logic prev_q, prev_d;
  logic primed_q, primed_d;
  logic rise, fall;

  always_comb begin
    prev_d   = lvl_i;
    primed_d = 1'b1;
    rise     = primed_q & lvl_i & ~prev_q;
    fall     = primed_q & ~lvl_i & prev_q;
    unique case (det_i)
      DET_LEVEL: event_o = (lvl_i == pol_i);
      DET_RISE:  event_o = rise;
      DET_FALL:  event_o = fall;
      DET_BOTH:  event_o = rise | fall;
      default:   event_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      primed_q <= primed_d;
    end
  end
endmodule

// File: rtl/gir_status.sv
module gir_status (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  input  logic en_i,
  input  logic raw_en_i,
  input  logic dc_en_i,
  input  logic wr_en_i,
  input  logic wr_val_i,
  output logic status_o,
  output logic direct_o
);
  logic status_q, status_d, status_ld;
  logic direct_q, direct_d;

  always_comb begin
    status_ld = wr_en_i | (event_i & (en_i | raw_en_i));
    status_d  = wr_en_i ? wr_val_i : 1'b1;
    direct_d  = event_i & dc_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      direct_q <= 1'b0;
    end else begin
      if (status_ld) status_q <= status_d;
      direct_q <= direct_d;
    end
  end

  assign status_o = status_q;
  assign direct_o = direct_q;
endmodule

// File: rtl/gir_route.sv
module gir_route
  import gir_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic [NUM_PINS-1:0]            en_i,
  input  logic [NUM_PINS-1:0]            status_i,
  input  logic [NUM_PINS-1:0][TGT_W-1:0] tgt_i,
  output logic [NUM_TGT-1:0]             summary_o
);
  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int i = 0; i < NUM_PINS; i++) begin
        hit = hit | (en_i[i] & status_i[i] & (tgt_i[i] == TGT_W'(t)));
      end
    end
    assign summary_o[t] = hit;
  end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gir_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_PINS-1:0]       pin_lvl,
  input  logic [NUM_PINS*CFG_W-1:0] cfg_flat,
  input  logic [NUM_PINS-1:0]       sw_wr_en,
  input  logic [NUM_PINS-1:0]       sw_wr_val,
  output logic [NUM_PINS-1:0]       status_q,
  output logic [NUM_TGT-1:0]        summary_irq,
  output logic [NUM_PINS-1:0]       direct_irq
);
  pin_cfg_t [NUM_PINS-1:0]            cfg;
  logic     [NUM_PINS-1:0]            pin_event;
  logic     [NUM_PINS-1:0]            pin_en;
  logic     [NUM_PINS-1:0][TGT_W-1:0] pin_tgt;

  assign cfg = cfg_flat;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign pin_en[i]  = cfg[i].en;
    assign pin_tgt[i] = cfg[i].tgt;

    gir_detect u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_i   (pin_lvl[i]),
      .det_i   (cfg[i].det),
      .pol_i   (cfg[i].pol),
      .event_o (pin_event[i])
    );

    gir_status u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .event_i  (pin_event[i]),
      .en_i     (cfg[i].en),
      .raw_en_i (cfg[i].raw_en),
      .dc_en_i  (cfg[i].dc_en),
      .wr_en_i  (sw_wr_en[i]),
      .wr_val_i (sw_wr_val[i]),
      .status_o (status_q[i]),
      .direct_o (direct_irq[i])
    );
  end

  gir_route #(.NUM_PINS(NUM_PINS)) u_route (
    .en_i      (pin_en),
    .status_i  (status_q),
    .tgt_i     (pin_tgt),
    .summary_o (summary_irq)
  );
endmodule

// File: rtl/gir_checker.sv
module gir_checker
  import gir_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_PINS-1:0]       pin_lvl,
  input logic [NUM_PINS*CFG_W-1:0] cfg_flat,
  input logic [NUM_PINS-1:0]       sw_wr_en,
  input logic [NUM_PINS-1:0]       sw_wr_val,
  input logic [NUM_PINS-1:0]       status_q,
  input logic [NUM_TGT-1:0]        summary_irq,
  input logic [NUM_PINS-1:0]       direct_irq
);
  pin_cfg_t [NUM_PINS-1:0] c;
  assign c = cfg_flat;

  AST_SUM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> (summary_irq == '0)) else $error("summary without status"); // R9

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr_en[i] && !sw_wr_val[i]) |=> !status_q[i]) else $error("clear ignored"); // R7
    AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr_en[i] && sw_wr_val[i]) |=> status_q[i]) else $error("set ignored"); // R7
    AST_LEVEL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (c[i].det == DET_LEVEL && c[i].en && pin_lvl[i] == c[i].pol && !sw_wr_en[i])
      |=> status_q[i]) else $error("level event lost"); // R3
    AST_NO_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
      (!c[i].en && !c[i].raw_en && !sw_wr_en[i] && !status_q[i]) |=> !status_q[i])
      else $error("recorded while gated"); // R8
    AST_DIRECT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !c[i].dc_en |=> !direct_irq[i]) else $error("direct line while disabled"); // R10
    AST_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
      (c[i].en && status_q[i] && c[i].tgt < TGT_W'(NUM_TGT)) |-> summary_irq[c[i].tgt])
      else $error("summary not raised"); // R9
  end
endmodule

bind gpio_irq_router gir_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pin_lvl     (pin_lvl),
  .cfg_flat    (cfg_flat),
  .sw_wr_en    (sw_wr_en),
  .sw_wr_val   (sw_wr_val),
  .status_q    (status_q),
  .summary_irq (summary_irq),
  .direct_irq  (direct_irq)
);

// File: tb/gpio_irq_router_tb_top.sv
module gpio_irq_router_tb_top;
  localparam int NP = 4;
  localparam int CW = 9;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   pin_lvl = '0;
  logic [NP*CW-1:0] cfg_flat;
  logic [NP-1:0]   sw_wr_en = '0;
  logic [NP-1:0]   sw_wr_val = '0;
  logic [NP-1:0]   status_q;
  logic [5:0]      summary_irq;
  logic [NP-1:0]   direct_irq;

  logic [NP*CW-1:0] cfg_nx;
  int total = 0;
  int bad = 0;

  typedef struct {
    logic [NP-1:0] stat;
    logic [5:0]    sum;
    logic [NP-1:0] dir;
    string         tag;
  } exp_t;
  exp_t q[$];

  logic [NP-1:0] m_prev, m_primed, m_stat;

  always #5 clk = ~clk;

  gpio_irq_router #(.NUM_PINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .cfg_flat(cfg_flat),
    .sw_wr_en(sw_wr_en), .sw_wr_val(sw_wr_val), .status_q(status_q),
    .summary_irq(summary_irq), .direct_irq(direct_irq)
  );

  // word layout per R2
  function automatic logic [CW-1:0] mk(input logic en, input logic pol, input logic [1:0] det,
                                       input logic raw, input logic [2:0] tgt, input logic dc);
    return {dc, tgt, raw, det, pol, en};
  endfunction

  task automatic setc(input int p, input logic [CW-1:0] w);
    cfg_nx[p*CW +: CW] = w;
  endtask

  // called at a falling edge; drives, predicts, waits for the next falling edge
  task automatic step(input logic [NP-1:0] p, input logic [NP-1:0] we,
                      input logic [NP-1:0] wv, input string tag);
    exp_t e;
    e.dir = '0;
    e.sum = '0;
    cfg_flat = cfg_nx;
    pin_lvl = p; sw_wr_en = we; sw_wr_val = wv;
    for (int i = 0; i < NP; i++) begin
      logic [CW-1:0] w;
      logic rise, fall, ev;
      w = cfg_nx[i*CW +: CW];
      rise = m_primed[i] & p[i] & ~m_prev[i];
      fall = m_primed[i] & ~p[i] & m_prev[i];
      case (w[3:2])
        2'b00: ev = (p[i] == w[1]);
        2'b01: ev = rise;
        2'b10: ev = fall;
        default: ev = rise | fall;
      endcase
      if (we[i]) m_stat[i] = wv[i];
      else if (ev && (w[0] || w[4])) m_stat[i] = 1'b1;
      e.dir[i] = ev & w[8];
      m_prev[i] = p[i];
      m_primed[i] = 1'b1;
    end
    for (int i = 0; i < NP; i++) begin
      logic [CW-1:0] w;
      w = cfg_nx[i*CW +: CW];
      if (w[0] && m_stat[i] && w[7:5] < 3'd6) e.sum[w[7:5]] = 1'b1;
    end
    e.stat = m_stat;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (status_q !== e.stat || summary_irq !== e.sum || direct_irq !== e.dir) begin
          bad++;
          $display("FAIL %s: stat=%b sum=%b dir=%b expected stat=%b sum=%b dir=%b",
                   e.tag, status_q, summary_irq, direct_irq, e.stat, e.sum, e.dir);
        end
      end
    end
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) cfg_nx[i*CW +: CW] = mk(0, 0, 2'b00, 0, 3'd7, 0);
    cfg_flat = cfg_nx;
    m_prev = '0; m_primed = '0; m_stat = '0;
    setc(1, mk(1, 0, 2'b01, 0, 3'd1, 0));
    cfg_flat = cfg_nx;
    pin_lvl = 4'b0010;
    repeat (3) @(negedge clk);
    total++;
    if (status_q !== '0 || summary_irq !== '0 || direct_irq !== '0) begin
      bad++;
      $display("FAIL R1 reset: stat=%b sum=%b dir=%b expected all zero", status_q, summary_irq, direct_irq);
    end
    rst_n = 1'b1;
    // R1: pin 1 already high at release, rising mode -> no event
    step(4'b0010, '0, '0, "R1 first cycle no edge");
    step(4'b0010, '0, '0, "R1 hold high");
    step(4'b0000, '0, '0, "R1 fall");
    step(4'b0010, '0, '0, "R4 rise after reset");
    step(4'b0000, 4'b0010, 4'b0000, "R7 clear pin1");
    setc(1, mk(0, 0, 2'b00, 0, 3'd7, 0));

    // R3 level, active high, target 0
    setc(0, mk(1, 1, 2'b00, 0, 3'd0, 0));
    step(4'b0000, '0, '0, "R3 inactive level");
    step(4'b0001, '0, '0, "R3 active high sets");
    step(4'b0001, 4'b0001, 4'b0000, "R7 clear while active");
    step(4'b0001, '0, '0, "R3 re-set after clear");
    step(4'b0000, 4'b0001, 4'b0000, "R7 clear after low");
    setc(0, mk(1, 0, 2'b00, 0, 3'd0, 0));
    step(4'b0001, '0, '0, "R3 active low idle");
    step(4'b0000, '0, '0, "R3 active low sets");
    step(4'b0001, 4'b0001, 4'b0000, "R7 clear");

    // R4 / R5 / R6 share a waveform: low, rise, high, fall, low
    for (int k = 1; k < 4; k++) begin
      setc(0, mk(1, 0, k[1:0], 0, 3'd2, 0));
      step(4'b0000, 4'b0001, 4'b0000, "R4 R5 R6 prep low");
      step(4'b0001, '0, '0, "R4 R6 rise");
      step(4'b0001, 4'b0001, 4'b0000, "R4 clear while high");
      step(4'b0001, '0, '0, "R4 hold high no re-set");
      step(4'b0000, '0, '0, "R5 R6 fall");
      step(4'b0000, '0, '0, "R5 hold low");
    end
    step(4'b0000, 4'b0001, 4'b0000, "R7 clear");

    // R7 set by software on a disabled pin, and write beats event
    setc(0, mk(0, 0, 2'b00, 0, 3'd7, 0));
    step(4'b0000, 4'b0001, 4'b0001, "R7 software set");
    step(4'b0000, 4'b0001, 4'b0000, "R7 software clear");
    setc(0, mk(1, 1, 2'b00, 0, 3'd3, 0));
    step(4'b0001, 4'b0001, 4'b0000, "R7 write beats level event");
    step(4'b0000, 4'b0001, 4'b0000, "R7 clear");

    // R8 recording gate
    setc(0, mk(0, 1, 2'b00, 0, 3'd0, 0));
    step(4'b0001, '0, '0, "R8 gated no record");
    step(4'b0001, '0, '0, "R8 gated still none");
    setc(0, mk(0, 1, 2'b00, 1, 3'd0, 0));
    step(4'b0001, '0, '0, "R8 raw records without summary");
    setc(0, mk(1, 1, 2'b00, 1, 3'd0, 0));
    step(4'b0001, '0, '0, "R8 enable exposes summary");
    setc(0, mk(0, 0, 2'b00, 0, 3'd7, 0));
    step(4'b0000, 4'b0001, 4'b0000, "R8 clear");

    // R9 / R2 routing sweep, pins 2 and 3 share a target
    for (int t = 0; t < 8; t++) begin
      setc(2, mk(1, 1, 2'b00, 0, t[2:0], 0));
      setc(3, mk(1, 1, 2'b00, 0, t[2:0], 0));
      step(4'b1100, '0, '0, "R9 R2 target sweep");
      step(4'b0100, 4'b1000, 4'b0000, "R9 OR with one pin cleared");
    end
    setc(3, mk(1, 1, 2'b00, 0, 3'd4, 0));
    step(4'b1100, '0, '0, "R9 two targets at once");
    setc(2, mk(0, 0, 2'b00, 0, 3'd7, 0));
    setc(3, mk(0, 0, 2'b00, 0, 3'd7, 0));
    step(4'b0000, 4'b1100, 4'b0000, "R9 clear");

    // R10 direct line, independent of enable
    setc(3, mk(0, 0, 2'b01, 0, 3'd7, 1));
    step(4'b0000, '0, '0, "R10 idle");
    step(4'b1000, '0, '0, "R10 rise pulses direct");
    step(4'b1000, '0, '0, "R10 single cycle");
    setc(3, mk(1, 0, 2'b11, 0, 3'd5, 0));
    step(4'b0000, '0, '0, "R10 disabled no pulse");
    setc(3, mk(1, 0, 2'b11, 0, 3'd5, 1));
    step(4'b1000, '0, '0, "R10 both-edge pulse");
    step(4'b1000, 4'b1000, 4'b0000, "R10 clear");

    @(posedge clk); #5;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule